// File: doc/BRIEF.md
# Backplane Slot-Priority Parallel Arbiter

This block sits on a repeater backplane beside the slot boards and settles which board holds the identified port. Each slot has one request line, which is that board's chain-output. The arbiter compares all request lines at once and picks the lowest-numbered requesting slot. It registers that slot number and drives it onto a shared identification bus, together with a valid strobe.

The same procedure serves two arbitration phases, selected by the `phase` input: receive-activity arbitration while the repeater is idle, and collision-port arbitration during transmit collision. A result is held until one of two things happens: the phase input changes, or every request drops.

An empty slot has its request pulled inactive, so it can never win. Because the arbitration is parallel, a missing board does not disturb arbitration among the others. A bank of per-slot comparators models each board's strapped slot number. Each comparator gives a one-hot "identified" output for the board whose number matches the bus.

Top module: `bp_slot_arbiter`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `arb_valid` is 0, `arb_id` is 0 and `slot_hit` is all zero.
- R2: If no bit of `slot_req` is set at a rising clock edge, then after that edge `arb_valid` is 0 and `arb_id` is 0. This holds even if `phase` toggles at the same edge.
- R3: If `arb_valid` is 0 and at least one request is set at an edge, then after that edge `arb_valid` is 1. `arb_id` then equals the smallest index `k` with `slot_req[k]` set, so slot 0 has the highest priority.
- R4: While `arb_valid` is 1, `phase` is unchanged from the previous edge and some request remains set, `arb_id` keeps its value. This holds when a higher-priority slot starts requesting and when the winning slot itself withdraws.
- R5: `phase` uses 0 for idle receive arbitration and 1 for transmit-collision arbitration. A value at an edge that differs from the value at the previous edge, with at least one request set, re-arbitrates. `arb_id` becomes the smallest requesting index after that edge.
- R6: `slot_hit[k]` is 1 exactly when `arb_valid` is 1 and `arb_id` equals `k`. It is combinational from the registered bus.
- R7: A slot whose request stays 0 never appears on `arb_id` while `arb_valid` is 1. Slots above an empty run still win normally.
- R8: With all 16 requests set, the winner is slot 0. With only slot 15 set, the winner is slot 15, which is the full 4-bit code 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | input | 16 | One request per backplane slot, bit k is slot k, active high |
| phase | input | 1 | Arbitration phase: 0 idle receive, 1 transmit collision |
| arb_id | output | 4 | Registered slot number of the winner |
| arb_valid | output | 1 | High while `arb_id` names a requesting winner |
| slot_hit | output | 16 | Per-slot identified flag from each board's ID comparison |

## Verification
Two events can coincide at one edge: a phase toggle, which forces re-arbitration, and a change in the request set. The bench provokes both pairings. In one, the last request drops in the same cycle that `phase` flips, and the release must win, giving `arb_valid` 0. In the other, a higher-priority slot appears in the same cycle as the flip, and the new lower index must be taken instead of the held one. In each case the expected bus value, strobe and one-hot hit vector are queued and compared one cycle after the inputs are applied.

// File: rtl/bp_arb_pkg.sv
package bp_arb_pkg;

    typedef enum logic {
        PH_RX_IDLE = 1'b0,
        PH_TX_COLL = 1'b1
    } arb_phase_e;

endpackage

// File: rtl/slot_prio_enc.sv
module slot_prio_enc #(
    parameter int NUM_SLOTS = 16,
    localparam int IDW = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] req,
    output logic                 any,
    output logic [IDW-1:0]       idx
);

    // Lowest set index wins: scan downward so the last hit is the smallest.
    always_comb begin
        idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDW'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/slot_id_match.sv
module slot_id_match #(
    parameter int NUM_SLOTS = 16,
    localparam int IDW = $clog2(NUM_SLOTS)
) (
    input  logic [IDW-1:0]       bus_id,
    input  logic                 bus_valid,
    output logic [NUM_SLOTS-1:0] hit
);

    // One comparator per slot against its strapped number.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [IDW-1:0] STRAP = IDW'(g);
        assign hit[g] = bus_valid && (bus_id == STRAP);
    end

endmodule

// File: rtl/bp_slot_arbiter.sv
module bp_slot_arbiter
    import bp_arb_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int IDW = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic                 phase,
    output logic [IDW-1:0]       arb_id,
    output logic                 arb_valid,
    output logic [NUM_SLOTS-1:0] slot_hit
);

    typedef struct packed {
        logic [IDW-1:0] id;
        logic           valid;
        arb_phase_e     phase;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic           enc_any;
    logic [IDW-1:0] enc_idx;

    slot_prio_enc #(.NUM_SLOTS(NUM_SLOTS)) i_enc (
        .req (slot_req),
        .any (enc_any),
        .idx (enc_idx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.phase = arb_phase_e'(phase);
        if (!enc_any) begin
            state_d.valid = 1'b0;
            state_d.id    = '0;
        end else if (!state_q.valid || (arb_phase_e'(phase) != state_q.phase)) begin
            state_d.valid = 1'b1;
            state_d.id    = enc_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{id: '0, valid: 1'b0, phase: PH_RX_IDLE};
        end else begin
            state_q <= state_d;
        end
    end

    assign arb_id    = state_q.id;
    assign arb_valid = state_q.valid;

    slot_id_match #(.NUM_SLOTS(NUM_SLOTS)) i_match (
        .bus_id    (state_q.id),
        .bus_valid (state_q.valid),
        .hit       (slot_hit)
    );

endmodule

// File: rtl/bp_slot_arbiter_chk.sv
module bp_slot_arbiter_chk #(
    parameter int NUM_SLOTS = 16,
    localparam int IDW = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SLOTS-1:0] slot_req,
    input logic                 phase,
    input logic [IDW-1:0]       arb_id,
    input logic                 arb_valid,
    input logic [NUM_SLOTS-1:0] slot_hit
);

    logic [NUM_SLOTS-1:0] req_q;
    logic                 phase_q;

    always_ff @(posedge clk) begin
        req_q   <= slot_req;
        phase_q <= phase;
    end

    logic [NUM_SLOTS-1:0] below_mask;
    assign below_mask = (NUM_SLOTS'(1) << arb_id) - NUM_SLOTS'(1);

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req == '0) |=> (!arb_valid && arb_id == '0)); // R2

    AST_FIRST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_valid && slot_req != '0) |=> (arb_valid && req_q[arb_id] && (req_q & below_mask) == '0)); // R3

    AST_HOLD_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_valid && slot_req != '0 && phase == phase_q) |=> (arb_valid && $stable(arb_id))); // R4

    AST_PHASE_REARB: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_valid && slot_req != '0 && phase != phase_q) |=> (arb_valid && req_q[arb_id] && (req_q & below_mask) == '0)); // R5

    AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> (slot_hit[arb_id] && $onehot(slot_hit))); // R6

    AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_valid |-> (slot_hit == '0)); // R6

    AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_valid) |-> req_q[arb_id]); // R7

endmodule

bind bp_slot_arbiter bp_slot_arbiter_chk #(.NUM_SLOTS(NUM_SLOTS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_req  (slot_req),
    .phase     (phase),
    .arb_id    (arb_id),
    .arb_valid (arb_valid),
    .slot_hit  (slot_hit)
);

// File: tb/test_bp_slot_arbiter.sv
module test_bp_slot_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] slot_req = '0;
    logic        phase = 1'b0;
    logic [3:0]  arb_id;
    logic        arb_valid;
    logic [15:0] slot_hit;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       v;
        logic [3:0] id;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    bp_slot_arbiter i_bp_slot_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_req  (slot_req),
        .phase     (phase),
        .arb_id    (arb_id),
        .arb_valid (arb_valid),
        .slot_hit  (slot_hit)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply inputs at a falling edge, queue what must appear after the next rise.
    task automatic step(input logic [15:0] req, input logic ph,
                        input logic ev, input logic [3:0] eid, input string tag);
        exp_t e;
        @(negedge clk);
        slot_req = req;
        phase    = ph;
        e.v = ev; e.id = eid; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: sample mid-cycle after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " valid"}, {15'd0, arb_valid}, {15'd0, e.v});
                check({e.tag, " id"}, {12'd0, arb_id}, {12'd0, (e.v ? e.id : 4'd0)});
                check({e.tag, " R6 hit"}, slot_hit, e.v ? (16'd1 << e.id) : 16'd0);
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset valid", {15'd0, arb_valid}, 16'd0);
        check("R1 reset id", {12'd0, arb_id}, 16'd0);
        check("R1 reset hit", slot_hit, 16'd0);
        slot_req = 16'h0003;
        @(negedge clk);
        rst_n = 1'b1;
        slot_req = 16'h0000;

        step(16'h0000, 1'b0, 1'b0, 4'd0,  "R2 no request");
        step(16'h0010, 1'b0, 1'b1, 4'd4,  "R3 single slot 4");
        step(16'h0011, 1'b0, 1'b1, 4'd4,  "R4 higher arrives held");
        step(16'h0001, 1'b0, 1'b1, 4'd4,  "R4 winner withdraws held");
        step(16'h0001, 1'b1, 1'b1, 4'd0,  "R5 phase to collision");
        step(16'h0000, 1'b1, 1'b0, 4'd0,  "R2 release");
        step(16'h0A50, 1'b1, 1'b1, 4'd4,  "R3 pattern lowest 4");
        step(16'h0000, 1'b1, 1'b0, 4'd0,  "R2 release");
        step(16'hFFFF, 1'b1, 1'b1, 4'd0,  "R8 all request");
        step(16'h8000, 1'b0, 1'b1, 4'd15, "R8 only 15 on phase flip R5");
        step(16'h0000, 1'b1, 1'b0, 4'd0,  "R2 drop with phase flip");
        step(16'h8000, 1'b1, 1'b1, 4'd15, "R8 only slot 15");
        step(16'h8001, 1'b0, 1'b1, 4'd0,  "R5 flip with higher arrival");
        step(16'h8001, 1'b0, 1'b1, 4'd0,  "R4 steady hold");
        step(16'h0000, 1'b0, 1'b0, 4'd0,  "R2 release");
        // Slots 0..5 empty from here on.
        step(16'h0140, 1'b0, 1'b1, 4'd6,  "R7 empty low slots skipped");
        step(16'h0100, 1'b1, 1'b1, 4'd8,  "R7 rearb past empties");
        step(16'h0000, 1'b1, 1'b0, 4'd0,  "R2 release");

        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule